// File: doc/BRIEF.md
# Parallel Prefix Binary Adder (Logarithmic-Depth Tree)

This block adds two unsigned operands and a carry-in in a single combinational path. It returns the sum word and the carry-out. The carries are not rippled. An input stage forms a propagate bit and a generate bit for every position, and the carry-in is merged into position 0. A prefix network then combines these bit pairs with the associative carry operator.

The network has two sweeps, each of which pairs spans with a blocking factor of two. The up-sweep pairs neighbouring spans level by level. It produces the group generate for every span that ends one below a power-of-two boundary, and the last of these is the carry-out. The down-sweep then fills in the carries that lie between those boundaries. A final XOR stage forms the sum bits.

The width is a parameter and must be a power of two, at least 2. With `L = log2(WIDTH)`, the tree has `2L-1` operator stages.

Top module: `bk_prefix_adder`

## Requirements
- R1: `sum` equals the low `WIDTH` bits of `x + y + cin` for every input combination.
- R2: `cout` equals bit `WIDTH` of `x + y + cin`.
- R3: The carry-in enters at bit 0. With `x = y = 0`, `sum` equals `cin` and `cout` is 0.
- R4: When every position propagates (`x ^ y` all ones), `cout` equals `cin` and `sum` is all ones when `cin` is 0, or all zeros when `cin` is 1.
- R5: When `x == y`, the result is a left shift: `sum = {x[WIDTH-2:0], cin}` and `cout = x[WIDTH-1]`.
- R6: A carry born at bit 0 reaches every power-of-two boundary. For example, `x = 2^k - 1` with `y = 1` gives `sum = 2^k`, for k = 4, 8 and 15.
- R7: The same description is correct at other power-of-two widths. At `WIDTH = 4`, all 512 combinations of `x`, `y` and `cin` obey R1 and R2.
- R8: The result does not depend on operand order: swapping `x` and `y` leaves `sum` and `cout` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum word |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that must pass through every level of both sweeps. This happens when a carry starts at bit 0 and every higher position only propagates, so a wrong operator at any one node changes the result. Random operands almost never produce long propagate runs. The vector table therefore forces them directly with all-ones and alternating-bit operands, with the carry coming from `cin` or from a generate at bit 0. The exhaustive run at width 4 then reaches every node configuration of a smaller tree.

// File: rtl/bk_prefix_adder.sv
`timescale 1ns/1ps
module bk_prefix_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int LEVELS = $clog2(WIDTH);
  localparam int STAGES = 2*LEVELS - 1;

  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] pp [0:STAGES-1];
  logic [WIDTH-1:0] gp [0:STAGES];

  assign bit_p = x ^ y;
  assign pp[0] = bit_p;
  assign gp[0] = {x[WIDTH-1:1] & y[WIDTH-1:1], (x[0] & y[0]) | (bit_p[0] & cin)};

  for (genvar s = 1; s <= STAGES; s++) begin : stage
    localparam int LVL  = (s <= LEVELS) ? s : STAGES + 1 - s;
    localparam int SPAN = 1 << LVL;
    localparam int HALF = SPAN / 2;
    for (genvar i = 0; i < WIDTH; i++) begin : col
      if ((s <= LEVELS && ((i + 1) % SPAN) == 0) ||
          (s >  LEVELS && i >= SPAN && ((i + 1) % SPAN) == HALF)) begin : op
        assign gp[s][i] = gp[s-1][i] | (pp[s-1][i] & gp[s-1][i-HALF]);
        if (s < STAGES) begin : pg
          assign pp[s][i] = pp[s-1][i] & pp[s-1][i-HALF];
        end
      end else begin : pass
        assign gp[s][i] = gp[s-1][i];
        if (s < STAGES) begin : pg
          assign pp[s][i] = pp[s-1][i];
        end
      end
    end
  end

  assign sum  = bit_p ^ {gp[STAGES][WIDTH-2:0], cin};
  assign cout = gp[STAGES][WIDTH-1];
endmodule

// File: rtl/bk_prefix_adder_chk.sv
`timescale 1ns/1ps
module bk_prefix_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] x,
  input logic [WIDTH-1:0] y,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  logic [WIDTH:0] golden;
  assign golden = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    assert_sum_value_R1: assert (sum === golden[WIDTH-1:0]);
    assert_carry_out_R2: assert (cout === golden[WIDTH]);
    if (x == '0 && y == '0)
      assert_cin_at_bit0_R3: assert (sum === {{(WIDTH-1){1'b0}}, cin} && cout === 1'b0);
    if (&(x ^ y))
      assert_full_propagate_R4: assert (cout === cin);
    if (x == y)
      assert_double_shift_R5: assert (sum === {x[WIDTH-2:0], cin} && cout === x[WIDTH-1]);
  end
endmodule

bind bk_prefix_adder bk_prefix_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/bk_prefix_adder_tb_top.sv
`timescale 1ns/1ps
module bk_prefix_adder_tb_top;
  localparam int W = 16;
  localparam int NV = 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] x, y, sum;
  logic cin, cout;
  logic [3:0] x4, y4, sum4;
  logic cin4, cout4;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bk_prefix_adder #(.WIDTH(W)) dut_i (.x(x), .y(y), .cin(cin), .sum(sum), .cout(cout));
  bk_prefix_adder #(.WIDTH(4)) dut_w4_i (.x(x4), .y(y4), .cin(cin4), .sum(sum4), .cout(cout4));

  // x, y, cin, expected {cout,sum}
  localparam logic [15:0] TX [NV] = '{16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h000F,
                                      16'h00FF, 16'h7FFF, 16'hAAAA, 16'hAAAA, 16'h1234, 16'h8000,
                                      16'h0007, 16'h1234};
  localparam logic [15:0] TY [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'hFFFF, 16'h0001,
                                      16'h0001, 16'h0001, 16'h5555, 16'h5555, 16'h4321, 16'h8000,
                                      16'h0009, 16'h1234};
  localparam logic TC [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                               1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [16:0] TE [NV] = '{17'h00000, 17'h00001, 17'h10000, 17'h10000, 17'h1FFFF,
                                      17'h00010, 17'h00100, 17'h08000, 17'h0FFFF, 17'h10000,
                                      17'h05555, 17'h10000, 17'h00010, 17'h02469};
  localparam string TR [NV] = '{"R1", "R3", "R4", "R6", "R2", "R6", "R6", "R6", "R4", "R4",
                                "R1", "R5", "R2", "R5"};

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply16(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(posedge clk);
    x = a; y = b; cin = c;
    @(negedge clk);
  endtask

  initial begin
    x = '0; y = '0; cin = 1'b0;
    x4 = '0; y4 = '0; cin4 = 1'b0;
    @(negedge clk);
    check("R1 idle", {cout, sum}, 17'h0);

    for (int k = 0; k < NV; k++) begin
      apply16(TX[k], TY[k], TC[k]);
      check(TR[k], {cout, sum}, TE[k]);
      apply16(TY[k], TX[k], TC[k]);
      check("R8", {cout, sum}, TE[k]);
    end

    for (int k = 0; k < 512; k++) begin
      logic [4:0] exp4;
      @(posedge clk);
      x4 = k[3:0]; y4 = k[7:4]; cin4 = k[8];
      @(negedge clk);
      exp4 = {1'b0, x4} + {1'b0, y4} + {4'b0, cin4};
      check("R7", {12'h0, cout4, sum4}, {12'h0, exp4});
    end

    for (int k = 0; k < 2000; k++) begin
      logic [W:0] exp;
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      apply16(a, b, k[0]);
      exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, k[0]};
      check("R1/R2 random", {cout, sum}, exp);
    end

    apply16(16'hFFFF, 16'h0000, 1'b0);
    check("R4 no cin", {cout, sum}, 17'h0FFFF);
    apply16(16'hC3A5, 16'hC3A5, 1'b0);
    check("R5 shift", {cout, sum}, 17'h1874A);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule